// File: doc/BRIEF.md
# Vector Halfword Lane Load Unit

This block carries out one indexed halfword load into a single 16-bit lane of a 128-bit vector register. A start pulse presents a 32-bit instruction word, two 64-bit general-purpose register values (base and index) and the present contents of the destination vector. The block decodes the word and forms the effective address. It issues one halfword read on a request/response memory port, then inserts the returned halfword into the lane chosen by the address. The merged vector comes out with a one-cycle write-enable and the destination register number.

The register files, caches, translation and exceptions sit outside the block. The caller reads the register files and writes the result back. Only the addressed lane changes, and every other lane returns exactly as it was given.

Top module: `vec_half_lane_load`

## Requirements
- R1: An instruction matches when instr_i[31:26] equals 31 and instr_i[10:1] equals 39. instr_i[0] (record flag) is ignored, so a matching word with that bit set behaves exactly like one with it clear.
- R2: When start_i is high in the idle state and the word does not match, illegal_o is high in that same cycle, and no memory request and no vector write follow.
- R3: The base register number is instr_i[20:16]. When that field is 0, the base is the constant zero whatever gpr_a_i holds.
- R4: The effective address is the 64-bit sum of base and index, wrapping modulo 2^64, truncated to its low 32 bits. mem_addr_o equals that value with bit 0 forced to 0.
- R5: In the cycle after an accepted start, mem_req_o rises. It stays high with a stable mem_addr_o until the cycle in which mem_rvalid_i is high.
- R6: The lane index is bits 3..1 of the unaligned effective address. Lane L occupies vwr_data_o bits [127-16L : 112-16L], so lane 0 is bits 127:112.
- R7: Byte order is big-endian. mem_rdata_i[15:8] is the byte at the even address and becomes the lane's upper byte (vector byte 2L, counted from the most significant byte). mem_rdata_i[7:0] becomes byte 2L+1.
- R8: The seven other lanes of vwr_data_o equal vsrc_i as sampled at the accepted start. Later changes to vsrc_i have no effect.
- R9: In the cycle after the response, vwr_en_o and done_o are high for exactly one cycle, and vwr_idx_o equals instr_i[25:21] of the accepted word. The block is idle again in the following cycle.
- R10: start_i while an operation is in progress (waiting or writing back) is ignored. It raises no illegal_o and launches nothing.
- R11: mem_rvalid_i while no request is outstanding is ignored and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, accepted only when idle |
| instr_i | input | 32 | Instruction word |
| gpr_a_i | input | 64 | Value of the base register |
| gpr_b_i | input | 64 | Value of the index register |
| vsrc_i | input | 128 | Present destination vector contents |
| illegal_o | output | 1 | Decode mismatch on an idle start (combinational) |
| mem_req_o | output | 1 | Read request, held until the response |
| mem_addr_o | output | 32 | Halfword-aligned read address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 16 | Read halfword, even-address byte in [15:8] |
| vwr_en_o | output | 1 | Vector write-enable pulse |
| vwr_idx_o | output | 5 | Destination vector register number |
| vwr_data_o | output | 128 | Merged vector |
| done_o | output | 1 | Completion pulse |

## Verification
Two functions can land in the same cycle. The first pair is the launch of the memory request and its acceptance: the response arrives in the very first cycle that mem_req_o is high, with zero latency. The second pair is write-back and a new start: a start pulse is driven exactly in the write-enable cycle and during the wait. The bench's behavioural model expects the first write to complete untouched, and no second request or illegal flag to follow. Every output is compared against that model on every clock, so a design that accepted the early start or dropped the zero-latency response shows a mismatch in the cycle it happens.

// File: rtl/vhl_pkg.sv
`timescale 1ns/1ps
package vhl_pkg;
  localparam logic [5:0] PRIM_OP = 6'd31;
  localparam logic [9:0] EXT_OP  = 10'd39;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_WB   = 2'd2
  } vhl_state_e;

  typedef struct packed {
    logic [4:0] vrt;
    logic [4:0] ra;
    logic [4:0] rb;
  } vhl_fields_t;
endpackage

// File: rtl/vhl_decode.sv
`timescale 1ns/1ps
module vhl_decode
  import vhl_pkg::*;
(
  input  logic [31:0] instr,
  output logic        match,
  output vhl_fields_t fields
);
  logic [5:0] prim;
  logic [9:0] ext;

  always_comb begin
    prim       = instr[31:26];
    ext        = instr[10:1];
    fields.vrt = instr[25:21];
    fields.ra  = instr[20:16];
    fields.rb  = instr[15:11];
    match      = (prim == PRIM_OP) && (ext == EXT_OP);
  end
endmodule

// File: rtl/vhl_agu.sv
`timescale 1ns/1ps
module vhl_agu #(
  parameter int XLEN   = 64,
  parameter int AW     = 32,
  parameter int EBYTES = 2,
  parameter int VBYTES = 16,
  localparam int OFF_W  = $clog2(EBYTES),
  localparam int LANE_W = $clog2(VBYTES / EBYTES)
) (
  input  logic [4:0]        ra_field,
  input  logic [XLEN-1:0]   base,
  input  logic [XLEN-1:0]   index,
  output logic [AW-1:0]     addr_aligned,
  output logic [LANE_W-1:0] lane
);
  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] ea;
  logic [AW-1:0]   ea_lo;

  always_comb begin
    base_eff     = (ra_field == 5'd0) ? '0 : base;
    ea           = base_eff + index;
    ea_lo        = ea[AW-1:0];
    addr_aligned = {ea_lo[AW-1:OFF_W], {OFF_W{1'b0}}};
    lane         = ea_lo[OFF_W +: LANE_W];
  end
endmodule

// File: rtl/vhl_merge.sv
`timescale 1ns/1ps
module vhl_merge #(
  parameter int VW = 128,
  parameter int EW = 16,
  localparam int LANES  = VW / EW,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [VW-1:0]     vsrc,
  input  logic [LANE_W-1:0] lane,
  input  logic [EW-1:0]     elem,
  output logic [VW-1:0]     merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[VW-1-g*EW -: EW] =
      (lane == LANE_W'(g)) ? elem : vsrc[VW-1-g*EW -: EW];
  end
endmodule

// File: rtl/vec_half_lane_load.sv
`timescale 1ns/1ps
module vec_half_lane_load
  import vhl_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 32,
  parameter int VW   = 128,
  parameter int EW   = 16,
  localparam int LANES  = VW / EW,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] gpr_a_i,
  input  logic [XLEN-1:0] gpr_b_i,
  input  logic [VW-1:0]   vsrc_i,
  output logic            illegal_o,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [EW-1:0]   mem_rdata_i,
  output logic            vwr_en_o,
  output logic [4:0]      vwr_idx_o,
  output logic [VW-1:0]   vwr_data_o,
  output logic            done_o
);
  vhl_state_e  state_q, state_d;
  logic        dec_match;
  vhl_fields_t dec_f;
  logic [AW-1:0]     agu_addr;
  logic [LANE_W-1:0] agu_lane;
  logic [VW-1:0]     merged;

  logic [AW-1:0]     addr_q;
  logic [LANE_W-1:0] lane_q;
  logic [4:0]        idx_q;
  logic [VW-1:0]     vsrc_q;
  logic [VW-1:0]     wdata_q;

  logic idle, accept, resp, launch_en, resp_en;

  vhl_decode u_dec (
    .instr  (instr_i),
    .match  (dec_match),
    .fields (dec_f)
  );

  vhl_agu #(.XLEN(XLEN), .AW(AW), .EBYTES(EW/8), .VBYTES(VW/8)) u_agu (
    .ra_field     (dec_f.ra),
    .base         (gpr_a_i),
    .index        (gpr_b_i),
    .addr_aligned (agu_addr),
    .lane         (agu_lane)
  );

  vhl_merge #(.VW(VW), .EW(EW)) u_mrg (
    .vsrc   (vsrc_q),
    .lane   (lane_q),
    .elem   (mem_rdata_i),
    .merged (merged)
  );

  always_comb begin
    idle      = (state_q == ST_IDLE);
    accept    = idle && start_i && dec_match;
    resp      = (state_q == ST_WAIT) && mem_rvalid_i;
    launch_en = accept;
    resp_en   = resp;
    illegal_o = idle && start_i && !dec_match;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_WAIT;
      ST_WAIT: if (resp)   state_d = ST_WB;
      ST_WB:               state_d = ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lane_q <= '0;
      idx_q  <= '0;
      vsrc_q <= '0;
    end else if (launch_en) begin
      addr_q <= agu_addr;
      lane_q <= agu_lane;
      idx_q  <= dec_f.vrt;
      vsrc_q <= vsrc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wdata_q <= '0;
    else if (resp_en) wdata_q <= merged;
  end

  assign mem_req_o  = (state_q == ST_WAIT);
  assign mem_addr_o = addr_q;
  assign vwr_en_o   = (state_q == ST_WB);
  assign done_o     = (state_q == ST_WB);
  assign vwr_idx_o  = idx_q;
  assign vwr_data_o = wdata_q;

  // Lanes of the written vector that differ from the captured source
  logic [LANES-1:0] lane_diff;
  for (genvar g = 0; g < LANES; g++) begin : g_diff
    assign lane_diff[g] = (vwr_data_o[VW-1-g*EW -: EW] != vsrc_q[VW-1-g*EW -: EW]);
  end

  p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !illegal_o && !mem_req_o && !vwr_en_o) |=> mem_req_o);
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_addr_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !mem_addr_o[0]);
  p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> (!mem_req_o && !vwr_en_o));
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o || vwr_en_o) |-> !illegal_o);
  p_writeback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rvalid_i) |=> (vwr_en_o && done_o));
  p_wb_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vwr_en_o |=> !vwr_en_o);
  p_stray_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_o && mem_rvalid_i) |=> !vwr_en_o);
  p_one_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vwr_en_o |-> ($countones(lane_diff) <= 1));
endmodule

// File: tb/vec_half_lane_load_test.sv
`timescale 1ns/1ps
module vec_half_lane_load_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [31:0]  instr_i;
  logic [63:0]  gpr_a_i, gpr_b_i;
  logic [127:0] vsrc_i;
  logic         illegal_o, mem_req_o, mem_rvalid_i, vwr_en_o, done_o;
  logic [31:0]  mem_addr_o;
  logic [15:0]  mem_rdata_i;
  logic [4:0]   vwr_idx_o;
  logic [127:0] vwr_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vec_half_lane_load uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
    .gpr_a_i(gpr_a_i), .gpr_b_i(gpr_b_i), .vsrc_i(vsrc_i),
    .illegal_o(illegal_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .vwr_en_o(vwr_en_o), .vwr_idx_o(vwr_idx_o), .vwr_data_o(vwr_data_o),
    .done_o(done_o)
  );

  // Behavioural reference state: 0 idle, 1 waiting, 2 write-back
  int           m_phase;
  logic [31:0]  m_addr;
  int           m_lane;
  logic [4:0]   m_idx;
  logic [127:0] m_vsrc;
  logic [127:0] m_out;

  function automatic logic [31:0] mk(input logic [4:0] vrt, input logic [4:0] ra,
                                     input logic [4:0] rb, input logic rc);
    return {6'd31, vrt, ra, rb, 10'd39, rc};
  endfunction

  function automatic bit is_match(input logic [31:0] w);
    return (w[31:26] == 6'd31) && (w[10:1] == 10'd39);
  endfunction

  function automatic logic [127:0] ref_insert(input logic [127:0] v, input int lane,
                                              input logic [15:0] h);
    logic [127:0] r;
    int hi;
    r = v;
    hi = 2 * lane;
    r[127 - 8*hi -: 8]       = h[15:8];
    r[127 - 8*(hi + 1) -: 8] = h[7:0];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_now();
    bit exp_ill;
    exp_ill = (m_phase == 0) && start_i && !is_match(instr_i);
    chk("R2 illegal_o (R1 decode, R10 busy)", 128'(illegal_o), 128'(exp_ill));
    chk("R5 mem_req_o", 128'(mem_req_o), 128'(m_phase == 1));
    chk("R9 vwr_en_o (R11 stray)", 128'(vwr_en_o), 128'(m_phase == 2));
    chk("R9 done_o", 128'(done_o), 128'(m_phase == 2));
    if (m_phase == 1) chk("R4 mem_addr_o (R3 base)", 128'(mem_addr_o), 128'(m_addr));
    if (m_phase == 2) begin
      chk("R9 vwr_idx_o", 128'(vwr_idx_o), 128'(m_idx));
      chk("R8 vwr_data_o (R6 lane, R7 order)", vwr_data_o, m_out);
    end
  endtask

  task automatic model_step();
    longint unsigned base, ea;
    if (m_phase == 0) begin
      if (start_i && is_match(instr_i)) begin
        base    = (instr_i[20:16] == 5'd0) ? 64'd0 : gpr_a_i;
        ea      = base + gpr_b_i;
        m_addr  = ea[31:0] & 32'hFFFF_FFFE;
        m_lane  = int'((ea >> 1) & 64'd7);
        m_idx   = instr_i[25:21];
        m_vsrc  = vsrc_i;
        m_phase = 1;
      end
    end else if (m_phase == 1) begin
      if (mem_rvalid_i) begin
        m_out   = ref_insert(m_vsrc, m_lane, mem_rdata_i);
        m_phase = 2;
      end
    end else begin
      m_phase = 0;
    end
  endtask

  task automatic cycle();
    #1;
    compare_now();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic op(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                    input logic [127:0] v, input logic [15:0] h, input int lat,
                    input bit poke);
    start_i = 1'b1; instr_i = w; gpr_a_i = a; gpr_b_i = b; vsrc_i = v;
    cycle();
    start_i = 1'b0;
    vsrc_i = {$urandom, $urandom, $urandom, $urandom};   // R8: later changes ignored
    for (int i = 0; i < lat; i++) begin
      if (poke) begin start_i = 1'b1; instr_i = 32'h0; end   // R10 during wait
      cycle();
      start_i = 1'b0;
    end
    mem_rvalid_i = 1'b1; mem_rdata_i = h;
    cycle();
    mem_rvalid_i = 1'b0; mem_rdata_i = 16'hDEAD;
    if (poke) begin start_i = 1'b1; instr_i = mk(5'd9, 5'd0, 5'd0, 1'b0); end  // R10 at write-back
    cycle();
    start_i = 1'b0;
    cycle();
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; instr_i = '0; gpr_a_i = '0; gpr_b_i = '0;
    vsrc_i = '0; mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    m_phase = 0; m_addr = '0; m_lane = 0; m_idx = '0; m_vsrc = '0; m_out = '0;
    repeat (3) @(negedge clk);
    chk("reset mem_req_o", 128'(mem_req_o), 128'(0));
    chk("reset vwr_en_o", 128'(vwr_en_o), 128'(0));
    chk("reset done_o", 128'(done_o), 128'(0));
    rst_n = 1'b1;
    cycle();

    // R6 / R7: every lane, mixed latencies, even and odd addresses
    for (int l = 0; l < 8; l++) begin
      op(mk(5'(l + 3), 5'd5, 5'd7, 1'b0), 64'h0000_0000_0000_1000,
         64'(2*l + (l % 2)), 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF ^ 128'(l),
         16'hA500 | 16'(l), l % 3, 1'b0);
    end
    // R3: base field 0 uses zero, not gpr_a_i
    op(mk(5'd1, 5'd0, 5'd4, 1'b0), 64'hDEAD_BEEF_0000_0F00, 64'h0000_0000_0000_200B,
       {8{16'h5A5A}}, 16'h1234, 1, 1'b0);
    // R4: wrap-around and upper-half truncation
    op(mk(5'd2, 5'd6, 5'd8, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd3,
       {8{16'hFFFF}}, 16'h0000, 0, 1'b0);
    op(mk(5'd31, 5'd6, 5'd8, 1'b0), 64'h1234_5678_0000_0000, 64'h0000_0000_8000_000F,
       {8{16'h0000}}, 16'hBEEF, 2, 1'b0);
    // R1: record bit set still executes
    op(mk(5'd12, 5'd3, 5'd3, 1'b1), 64'h40, 64'h5, {8{16'hC3C3}}, 16'h7E81, 1, 1'b0);
    // R10: start while waiting and at write-back is ignored
    op(mk(5'd17, 5'd1, 5'd2, 1'b0), 64'h100, 64'h9, {8{16'h1111}}, 16'h2222, 3, 1'b1);
    // R2 / R1: non-matching words
    start_i = 1'b1; instr_i = 32'h7800_004E;   // primary opcode 30
    cycle();
    instr_i = 32'h7C00_004C;                   // extended opcode 38
    cycle();
    start_i = 1'b0;
    cycle(); cycle();
    // R11: stray response while idle
    mem_rvalid_i = 1'b1; mem_rdata_i = 16'hFACE;
    cycle();
    mem_rvalid_i = 1'b0;
    cycle(); cycle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule